// File: doc/BRIEF.md
# Translation Fault Status and Fault Address Registers

This block holds the fault record for one context of an address translation unit. Fault events from the translation hardware arrive as a vector of cause flags with an address. Each flagged cause sets its own sticky status bit. The first fault that arrives while no cause bit is set also latches its address. A later fault, arriving while an earlier one is still unread, sets a multiple-faults flag and leaves the latched address alone.

Software reads the record through a small register port. It clears status bits with write-one-to-clear, so clearing an old fault cannot wipe out a fault that arrived in between. A control register enables the interrupt and stall-on-fault. When stall is enabled, a fault parks the context in a stalled state, shown by a status bit and an output pin. A resume pulse, or a write of one to the stalled bit, releases it.

A three-state machine tracks the context. ST_IDLE means no cause bit is set. ST_HELD means one or more cause bits are set and the context is not stalled. ST_STALLED means the context is stalled. The named transitions are:
- FAULT_LOG: ST_IDLE to ST_HELD, on a fault while stall is disabled.
- FAULT_STALL: any state to ST_STALLED, on a fault while stall is enabled.
- RELEASE: ST_STALLED to ST_HELD or ST_IDLE, on resume or a write-one to bit 30. The target depends on whether any cause bit remains.
- DRAIN: ST_HELD to ST_IDLE, once the last cause bit has been cleared.

Top module: `xlat_fault_status`

## Requirements
- R1: A fault event is `flt_valid` high with a nonzero `flt_cause`. On such an event, `flt_cause[k]` sets status bit k+1 for k = 0..6. The bits are 1 translation, 2 access, 3 permission, 4 TLB miss, 5 walk decode error, 6 walk slave error and 7 multiple TLB hits. Set bits stay set until they are cleared.
- R2: A fault event with `flt_second_level` high sets status bit 16.
- R3: The status register is at address 0. A read returns its current value, and unused bit positions read as zero. A write clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If a fault event and a clearing write target the same status bit in the same cycle, the bit ends up set.
- R5: The fault address is captured only on a fault event that arrives while status bits 1..7 are all zero. It then holds until a later such event. Address 1 reads its low 32 bits and address 2 reads the upper bits, zero-extended. Writes to addresses 1 and 2 have no effect.
- R6: Status bit 31 is set when a fault event arrives while any of bits 1..7 is already set. It is cleared by write-one.
- R7: Status bit 30 and the `stall` output are set by a fault event only while stall-enable is 1. They clear on `resume` or on a write-one to bit 30. A fault event in the same cycle as a release keeps the context stalled.
- R8: `irq` is high exactly while irq-enable is 1 and any of status bits 1..7 is set.
- R9: The control register is at address 3. Bit 0 is irq-enable and bit 1 is stall-enable. It reads back as written, with all other bits zero.
- R10: `flt_valid` with an all-zero `flt_cause` changes no state.
- R11: After reset the status, fault address and control registers are all zero, and `irq` and `stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 address low, 2 address high, 3 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| flt_valid | input | 1 | Fault event strobe |
| flt_cause | input | 7 | Fault cause flags, index k maps to status bit k+1 |
| flt_second_level | input | 1 | Fault occurred at the second table level |
| flt_addr | input | FAW | Faulting address |
| resume | input | 1 | Release a stalled context |
| irq | output | 1 | Fault interrupt |
| stall | output | 1 | Context is stalled |

## Verification
The bench builds the block with a 40-bit fault address. This makes the high address word partly populated, so the zero-extension of the upper bits is visible at address 2. With that width, an address captured on a first fault and another offered on an overlapping fault differ in both words. A held address is therefore distinguishable in both reads. The single-cycle collisions are driven directly: a set against a clear, and a fault against a resume.

// File: rtl/xfs_pkg.sv
package xfs_pkg;

    localparam int NUM_CAUSE = 7;
    localparam int CAUSE_LSB = 1;
    localparam int L2_BIT    = 16;
    localparam int SS_BIT    = 30;
    localparam int MULTI_BIT = 31;

    typedef enum logic [1:0] {
        RA_STATUS  = 2'd0,
        RA_ADDR_LO = 2'd1,
        RA_ADDR_HI = 2'd2,
        RA_CTRL    = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HELD    = 2'd1,
        ST_STALLED = 2'd2
    } ctx_state_e;

endpackage

// File: rtl/xfs_cause_bank.sv
module xfs_cause_bank
    import xfs_pkg::*;
#(
    parameter int NC = NUM_CAUSE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic [NC-1:0] cause,
    input  logic          l2_in,
    input  logic          clr_we,
    input  logic [NC-1:0] clr_cause,
    input  logic          clr_l2,
    input  logic          clr_multi,
    output logic [NC-1:0] cause_q,
    output logic          l2_q,
    output logic          multi_q,
    output logic          any_q,
    output logic          any_next
);

    logic [NC-1:0] cause_d;

    for (genvar k = 0; k < NC; k++) begin : g_bit
        logic set_k;
        logic clr_k;
        assign set_k = evt && cause[k];
        assign clr_k = clr_we && clr_cause[k];
        always_comb begin
            cause_d[k] = cause_q[k];
            if (clr_k) cause_d[k] = 1'b0;
            if (set_k) cause_d[k] = 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cause_q[k] <= 1'b0;
            else        cause_q[k] <= cause_d[k];
        end
    end

    assign any_q    = |cause_q;
    assign any_next = |cause_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l2_q    <= 1'b0;
            multi_q <= 1'b0;
        end else begin
            if (evt && l2_in)              l2_q <= 1'b1;
            else if (clr_we && clr_l2)     l2_q <= 1'b0;
            if (evt && any_q)              multi_q <= 1'b1;
            else if (clr_we && clr_multi)  multi_q <= 1'b0;
        end
    end

    AST_CAUSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> ((cause_q & $past(cause)) == $past(cause))); // R1
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && clr_we && |(cause & clr_cause)) |=> |cause_q); // R4
    AST_CLEAR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && clr_we) |=> (cause_q == ($past(cause_q) & ~$past(clr_cause)))); // R3
    AST_MULTI_ON_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && any_q) |=> multi_q); // R6
    AST_IDLE_EVT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !clr_we) |=> $stable(cause_q)); // R10

endmodule

// File: rtl/xfs_stall_fsm.sv
module xfs_stall_fsm
    import xfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic stall_en,
    input  logic release_req,
    input  logic any_next,
    output logic stalled
);

    ctx_state_e st_q;
    ctx_state_e st_d;
    logic       stall_evt;

    assign stall_evt = evt && stall_en;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (stall_evt)  st_d = ST_STALLED;  // FAULT_STALL
                else if (evt)   st_d = ST_HELD;     // FAULT_LOG
            end
            ST_HELD: begin
                if (stall_evt)      st_d = ST_STALLED;  // FAULT_STALL
                else if (!any_next) st_d = ST_IDLE;     // DRAIN
            end
            ST_STALLED: begin
                if (stall_evt)        st_d = ST_STALLED;                   // FAULT_STALL
                else if (release_req) st_d = any_next ? ST_HELD : ST_IDLE; // RELEASE
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        stalled = (st_q == ST_STALLED);
    end

    AST_STALL_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        stall_evt |=> stalled); // R7
    AST_NO_STALL_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!stalled && !stall_evt) |=> !stalled); // R7
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && release_req && !stall_evt) |=> !stalled); // R7

endmodule

// File: rtl/xfs_addr_latch.sv
module xfs_addr_latch #(
    parameter int FAW = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           evt,
    input  logic           any_q,
    input  logic [FAW-1:0] addr_in,
    output logic [FAW-1:0] addr_q
);

    logic capture;
    assign capture = evt && !any_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr_q <= '0;
        else if (capture) addr_q <= addr_in;
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        any_q |=> $stable(addr_q)); // R5
    AST_ADDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !any_q) |=> (addr_q == $past(addr_in))); // R5

endmodule

// File: rtl/xlat_fault_status.sv
module xlat_fault_status
    import xfs_pkg::*;
#(
    parameter int FAW = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 flt_valid,
    input  logic [NUM_CAUSE-1:0] flt_cause,
    input  logic                 flt_second_level,
    input  logic [FAW-1:0]       flt_addr,
    input  logic                 resume,
    output logic                 irq,
    output logic                 stall
);

    localparam int CAUSE_MSB = CAUSE_LSB + NUM_CAUSE - 1;

    logic                 evt;
    logic                 wr_status;
    logic                 wr_ctrl;
    logic [NUM_CAUSE-1:0] cause_q;
    logic                 l2_q;
    logic                 multi_q;
    logic                 any_q;
    logic                 any_next;
    logic                 stalled;
    logic [FAW-1:0]       addr_q;
    logic [63:0]          addr_ext;
    logic [1:0]           ctrl_q;
    logic                 release_req;
    logic [31:0]          status_word;
    logic                 wdata_unused;

    assign evt       = flt_valid && (|flt_cause);
    assign wr_status = reg_wr && (reg_addr == RA_STATUS);
    assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
    assign release_req = resume || (wr_status && reg_wdata[SS_BIT]);
    assign wdata_unused = ^{reg_wdata[29:17], reg_wdata[15:CAUSE_MSB+1],
                            reg_wdata[0]};

    xfs_cause_bank #(.NC(NUM_CAUSE)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .cause     (flt_cause),
        .l2_in     (flt_second_level),
        .clr_we    (wr_status),
        .clr_cause (reg_wdata[CAUSE_MSB:CAUSE_LSB]),
        .clr_l2    (reg_wdata[L2_BIT]),
        .clr_multi (reg_wdata[MULTI_BIT]),
        .cause_q   (cause_q),
        .l2_q      (l2_q),
        .multi_q   (multi_q),
        .any_q     (any_q),
        .any_next  (any_next)
    );

    xfs_stall_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .stall_en    (ctrl_q[1]),
        .release_req (release_req),
        .any_next    (any_next),
        .stalled     (stalled)
    );

    xfs_addr_latch #(.FAW(FAW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .any_q   (any_q),
        .addr_in (flt_addr),
        .addr_q  (addr_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= 2'b00;
        else if (wr_ctrl) ctrl_q <= reg_wdata[1:0];
    end

    assign addr_ext = 64'(addr_q);

    always_comb begin
        status_word = '0;
        status_word[CAUSE_MSB:CAUSE_LSB] = cause_q;
        status_word[L2_BIT]    = l2_q;
        status_word[SS_BIT]    = stalled;
        status_word[MULTI_BIT] = multi_q;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_STATUS:  reg_rdata = status_word;
            RA_ADDR_LO: reg_rdata = addr_ext[31:0];
            RA_ADDR_HI: reg_rdata = addr_ext[63:32];
            RA_CTRL:    reg_rdata = {30'd0, ctrl_q};
            default:    reg_rdata = '0;
        endcase
    end

    assign irq   = ctrl_q[0] && any_q;
    assign stall = stalled;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |-> !irq); // R8
    AST_IRQ_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_addr != RA_STATUS || |reg_rdata[CAUSE_MSB:CAUSE_LSB])); // R8
    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q)); // R9

endmodule

// File: tb/sim_xlat_fault_status.sv
`timescale 1ns/1ps
module sim_xlat_fault_status;

    localparam int FAW = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_addr = 2'd0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            flt_valid = 1'b0;
    logic [6:0]      flt_cause = '0;
    logic            flt_second_level = 1'b0;
    logic [FAW-1:0]  flt_addr = '0;
    logic            resume = 1'b0;
    logic            irq;
    logic            stall;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    xlat_fault_status #(.FAW(FAW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_valid(flt_valid),
        .flt_cause(flt_cause), .flt_second_level(flt_second_level),
        .flt_addr(flt_addr), .resume(resume), .irq(irq), .stall(stall)
    );

    // monitor: pops expected items and compares once the cycle has settled
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = reg_rdata;
                    1:       act = {31'd0, irq};
                    default: act = {31'd0, stall};
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle_inputs();
        reg_wr = 1'b0; reg_wdata = '0; flt_valid = 1'b0; flt_cause = '0;
        flt_second_level = 1'b0; resume = 1'b0;
    endtask

    task automatic drive(input logic wr, input logic [1:0] a, input logic [31:0] d,
                         input logic fv, input logic [6:0] c, input logic l2,
                         input logic [FAW-1:0] fa, input logic rs);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; flt_valid = fv;
        flt_cause = c; flt_second_level = l2; flt_addr = fa; resume = rs;
    endtask

    task automatic expect_read(input logic [1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        idle_inputs();
        reg_addr = a;
        it.kind = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_pin(input int kind, input logic v, input string tag);
        item_t it;
        it.kind = kind; it.exp = {31'd0, v}; it.tag = tag;
        sb.push_back(it);
    endtask

    localparam logic [FAW-1:0] A1 = 40'h12_3456_7890;
    localparam logic [FAW-1:0] A2 = 40'hAB_CDEF_0123;
    localparam logic [FAW-1:0] A3 = 40'h55_0000_1000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        expect_read(2'd0, 32'h0, "R11 status after reset");
        expect_pin(1, 1'b0, "R11 irq after reset");
        expect_pin(2, 1'b0, "R11 stall after reset");
        expect_read(2'd1, 32'h0, "R11 addr lo after reset");
        expect_read(2'd3, 32'h0, "R11 ctrl after reset");
        // R9 control
        drive(1, 2'd3, 32'hFFFF_FFF1, 0, 7'd0, 0, '0, 0);
        expect_read(2'd3, 32'h1, "R9 ctrl readback irq_en");
        // R1 R2 R5 first fault
        drive(0, 2'd0, 0, 1, 7'b0000001, 1, A1, 0);
        expect_read(2'd0, 32'h0001_0002, "R1 R2 first fault status");
        expect_pin(1, 1'b1, "R8 irq with fault and enable");
        expect_read(2'd1, 32'h3456_7890, "R5 addr lo captured");
        expect_read(2'd2, 32'h0000_0012, "R5 addr hi zero-extended");
        // R6 overlapping fault
        drive(0, 2'd0, 0, 1, 7'b0000100, 0, A2, 0);
        expect_read(2'd0, 32'h8001_000A, "R6 multi set on overlap");
        expect_read(2'd1, 32'h3456_7890, "R5 addr lo held on overlap");
        expect_read(2'd2, 32'h0000_0012, "R5 addr hi held on overlap");
        // R3 partial clear
        drive(1, 2'd0, 32'h0000_0002, 0, 7'd0, 0, '0, 0);
        expect_read(2'd0, 32'h8001_0008, "R3 clear one bit only");
        // R4 set wins
        drive(1, 2'd0, 32'h0000_0002, 1, 7'b0000001, 0, A3, 0);
        expect_read(2'd0, 32'h8001_000A, "R4 set beats clear");
        // R3 clear all
        drive(1, 2'd0, 32'hFFFF_FFFF, 0, 7'd0, 0, '0, 0);
        expect_read(2'd0, 32'h0, "R3 clear all");
        expect_pin(1, 1'b0, "R8 irq low when clear");
        // R10 zero cause ignored
        drive(0, 2'd0, 0, 1, 7'd0, 1, A3, 0);
        expect_read(2'd0, 32'h0, "R10 zero cause no status");
        expect_read(2'd1, 32'h3456_7890, "R10 zero cause no capture");
        // R7 stall
        drive(1, 2'd3, 32'h3, 0, 7'd0, 0, '0, 0);
        drive(0, 2'd0, 0, 1, 7'b0001000, 0, A2, 0);
        expect_read(2'd0, 32'h4000_0010, "R7 stalled status");
        expect_pin(2, 1'b1, "R7 stall pin");
        expect_read(2'd1, 32'hCDEF_0123, "R5 recapture after clear");
        drive(0, 2'd0, 0, 0, 7'd0, 0, '0, 1);
        expect_read(2'd0, 32'h0000_0010, "R7 resume clears stall");
        expect_pin(2, 1'b0, "R7 stall pin after resume");
        drive(0, 2'd0, 0, 1, 7'b0010000, 0, A1, 0);
        expect_read(2'd0, 32'hC000_0030, "R7 R6 stall and multi");
        drive(1, 2'd0, 32'h4000_0000, 0, 7'd0, 0, '0, 0);
        expect_read(2'd0, 32'h8000_0030, "R7 write-one releases");
        expect_pin(2, 1'b0, "R7 stall pin after write release");
        // R8 irq disabled
        drive(1, 2'd3, 32'h2, 0, 7'd0, 0, '0, 0);
        expect_read(2'd3, 32'h2, "R9 ctrl readback stall_en");
        expect_pin(1, 1'b0, "R8 irq masked");
        // R5 writes to address regs ignored
        drive(1, 2'd1, 32'hDEAD_BEEF, 0, 7'd0, 0, '0, 0);
        drive(1, 2'd2, 32'hDEAD_BEEF, 0, 7'd0, 0, '0, 0);
        expect_read(2'd1, 32'hCDEF_0123, "R5 addr lo write ignored");
        expect_read(2'd2, 32'h0000_00AB, "R5 addr hi write ignored");
        // R7 fault beats resume
        drive(1, 2'd0, 32'hFFFF_FFFF, 0, 7'd0, 0, '0, 0);
        drive(0, 2'd0, 0, 1, 7'b1000000, 0, A3, 1);
        expect_read(2'd0, 32'h4000_0080, "R7 fault beats resume");
        expect_pin(2, 1'b1, "R7 stall held over resume");
        expect_read(2'd2, 32'h0000_0055, "R5 addr hi third capture");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule